// File: doc/BRIEF.md
# Circular Reorder Buffer with Branch Rollback

This block keeps in-flight instructions in program order so that results produced out of order reach architectural state in order. Issue logic claims one slot per cycle at the allocate pointer and receives that slot's index. Execution units later report a result, together with an exception code, against that index. The oldest slot retires as soon as it has been marked executed. At most one slot retires per cycle. A retiring slot either presents its destination register and data, or, when it carries an exception code, empties the whole buffer so that a handler can be started.

A mispredicted branch truncates the buffer: the allocate pointer moves to the slot just after the branch and every younger slot is discarded. Several branches may be outstanding and may resolve in any order. When more than one mispredict port fires in the same cycle, the branch closest to the head decides. Stores are marked at allocation, and the store-permission output rises only when such a slot retires normally. Slots are used circularly and both pointers wrap.

Top module: `rob_top`

## Requirements
- R1: After reset, empty_o is 1, full_o is 0, alloc_ready_o is 1, alloc_idx_o is 0 and cmt_valid_o is 0.
- R2: Each accepted allocation takes the slot shown on alloc_idx_o. The index then advances by one modulo DEPTH, wrapping from DEPTH-1 to 0.
- R3: full_o rises when all DEPTH slots are occupied, and empty_o when none are. While full, alloc_ready_o is 0, an allocation request is refused, and alloc_idx_o does not move.
- R4: Completions may arrive in any order. The oldest slot retires only once it has been completed, with at most one retirement per cycle. While it retires, cmt_valid_o is 1 and cmt_dest_o and cmt_data_o show its destination and its completion data.
- R5: cmt_store_o is 1 exactly when a retiring slot was allocated with alloc_store_i set.
- R6: A completion cause of zero means no exception. If the oldest completed slot has a nonzero cause, cmt_excp_o is 1 with that cause on cmt_cause_o and cmt_valid_o is 0. From the next cycle the buffer is empty, and alloc_idx_o equals the index of the faulting slot.
- R7: A mispredict naming branch slot b sets alloc_idx_o to (b+1) mod DEPTH on the next cycle. Every slot younger than b is discarded and never retires.
- R8: When both mispredict ports are valid in one cycle, the branch nearer to the oldest slot determines the rollback and the other request is ignored.
- R9: A completion that names an unoccupied slot is ignored: a slot allocated there afterwards does not retire until it receives its own completion.
- R10: An allocation request in a cycle with an exception retirement or a rollback is discarded.
- R11: A rollback leaves the branch slot and all older slots in place, and they retire normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Allocation request |
| alloc_dest_i | input | DEST_W | Destination register of the new instruction |
| alloc_store_i | input | 1 | New instruction is a store |
| alloc_ready_o | output | 1 | A free slot is available |
| alloc_idx_o | output | IDX_W | Slot index the next allocation takes |
| cmpl_valid_i | input | 1 | Completion report |
| cmpl_idx_i | input | IDX_W | Slot being completed |
| cmpl_data_i | input | DATA_W | Result data |
| cmpl_cause_i | input | CAUSE_W | Exception code, zero for none |
| mp_valid_i | input | NUM_BR | Mispredict request per port |
| mp_idx_i | input | NUM_BR*IDX_W | Branch slot per port, port 0 in the low bits |
| cmt_valid_o | output | 1 | Oldest slot retires normally this cycle |
| cmt_dest_o | output | DEST_W | Destination of the retiring slot |
| cmt_data_o | output | DATA_W | Data of the retiring slot |
| cmt_store_o | output | 1 | Retiring slot may write memory |
| cmt_excp_o | output | 1 | Oldest slot retires with an exception |
| cmt_cause_o | output | CAUSE_W | Exception code of the oldest slot |
| full_o | output | 1 | All slots occupied |
| empty_o | output | 1 | No slot occupied |

## Verification
The assertions assume that every mispredict names a slot that holds an allocated branch. They also assume that a slot is completed at most once per allocation. The stimulus raises mispredicts only on branches it has allocated and not yet retired. It completes each slot once, apart from one deliberate completion aimed at a freed slot. It never asks for a rollback in a cycle in which the head is about to retire, so the expected-retirement queue can be trimmed from the young end without a race.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    FL_NONE = 2'd0,
    FL_EXCP = 2'd1,
    FL_ROLL = 2'd2
  } flush_e;
endpackage

// File: rtl/rob_oldest_sel.sv
module rob_oldest_sel
  import rob_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int NUM_BR = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0]        head_i,
  input  logic [NUM_BR-1:0]       mp_valid_i,
  input  logic [NUM_BR*IDX_W-1:0] mp_idx_i,
  output logic                    rb_valid_o,
  output logic [IDX_W-1:0]        rb_idx_o
);

  function automatic logic [IDX_W:0] age_of(logic [IDX_W-1:0] idx, logic [IDX_W-1:0] hd);
    if (idx >= hd) return {1'b0, idx} - {1'b0, hd};
    else           return {1'b0, idx} + (IDX_W+1)'(DEPTH) - {1'b0, hd};
  endfunction

  logic [IDX_W-1:0] br_idx [NUM_BR];
  logic [IDX_W:0]   br_age [NUM_BR];
  logic [IDX_W:0]   best_age;

  for (genvar p = 0; p < NUM_BR; p++) begin : g_port
    assign br_idx[p] = mp_idx_i[p*IDX_W +: IDX_W];
    assign br_age[p] = age_of(br_idx[p], head_i);
  end

  // smallest distance from head wins; ties keep lower port
  always_comb begin
    rb_valid_o = 1'b0;
    rb_idx_o   = '0;
    best_age   = '1;
    for (int p = 0; p < NUM_BR; p++) begin
      if (mp_valid_i[p] && (!rb_valid_o || br_age[p] < best_age)) begin
        rb_valid_o = 1'b1;
        rb_idx_o   = br_idx[p];
        best_age   = br_age[p];
      end
    end
  end

endmodule

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_fire_i,
  input  logic             commit_fire_i,
  input  flush_e           flush_i,
  input  logic [IDX_W-1:0] rb_idx_i,
  output logic [IDX_W-1:0] alloc_ptr_o,
  output logic [IDX_W-1:0] head_ptr_o
);

  function automatic logic [IDX_W-1:0] wrap_inc(logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_ptr_o <= '0;
    end else if (commit_fire_i) begin
      head_ptr_o <= wrap_inc(head_ptr_o);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alloc_ptr_o <= '0;
    end else begin
      unique case (flush_i)
        FL_EXCP: alloc_ptr_o <= head_ptr_o;
        FL_ROLL: alloc_ptr_o <= wrap_inc(rb_idx_i);
        default: if (alloc_fire_i) alloc_ptr_o <= wrap_inc(alloc_ptr_o);
      endcase
    end
  end

endmodule

// File: rtl/rob_entry_array.sv
module rob_entry_array
  import rob_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int DATA_W  = 32,
  parameter int DEST_W  = 5,
  parameter int CAUSE_W = 4,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               alloc_fire_i,
  input  logic [IDX_W-1:0]   alloc_ptr_i,
  input  logic [DEST_W-1:0]  alloc_dest_i,
  input  logic               alloc_store_i,
  input  logic               cmpl_valid_i,
  input  logic [IDX_W-1:0]   cmpl_idx_i,
  input  logic [DATA_W-1:0]  cmpl_data_i,
  input  logic [CAUSE_W-1:0] cmpl_cause_i,
  input  logic               commit_fire_i,
  input  logic [IDX_W-1:0]   head_ptr_i,
  input  flush_e             flush_i,
  input  logic [IDX_W-1:0]   rb_idx_i,
  output logic [DEPTH-1:0]   use_o,
  output logic [DEPTH-1:0]   exec_o,
  output logic [DEST_W-1:0]  head_dest_o,
  output logic [DATA_W-1:0]  head_data_o,
  output logic [CAUSE_W-1:0] head_cause_o,
  output logic               head_store_o
);

  function automatic logic [IDX_W:0] age_of(logic [IDX_W-1:0] idx, logic [IDX_W-1:0] hd);
    if (idx >= hd) return {1'b0, idx} - {1'b0, hd};
    else           return {1'b0, idx} + (IDX_W+1)'(DEPTH) - {1'b0, hd};
  endfunction

  logic [DEST_W-1:0]  dest_q  [DEPTH];
  logic [DATA_W-1:0]  data_q  [DEPTH];
  logic [CAUSE_W-1:0] cause_q [DEPTH];
  logic [DEPTH-1:0]   store_q;
  logic [IDX_W:0]     slot_age [DEPTH];
  logic [IDX_W:0]     rb_age;
  logic [DEPTH-1:0]   younger;

  assign rb_age = age_of(rb_idx_i, head_ptr_i);

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    assign slot_age[e] = age_of(IDX_W'(e), head_ptr_i);
    assign younger[e]  = slot_age[e] > rb_age;
  end

  // occupancy: exception clears all, rollback clears younger, retire clears head
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      use_o <= '0;
    end else if (flush_i == FL_EXCP) begin
      use_o <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (flush_i == FL_ROLL && younger[e]) begin
          use_o[e] <= 1'b0;
        end else if (commit_fire_i && head_ptr_i == IDX_W'(e)) begin
          use_o[e] <= 1'b0;
        end else if (alloc_fire_i && alloc_ptr_i == IDX_W'(e)) begin
          use_o[e] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exec_o  <= '0;
      store_q <= '0;
      for (int e = 0; e < DEPTH; e++) begin
        dest_q[e]  <= '0;
        data_q[e]  <= '0;
        cause_q[e] <= '0;
      end
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (alloc_fire_i && alloc_ptr_i == IDX_W'(e)) begin
          exec_o[e]  <= 1'b0;
          dest_q[e]  <= alloc_dest_i;
          store_q[e] <= alloc_store_i;
        end else if (cmpl_valid_i && cmpl_idx_i == IDX_W'(e) && use_o[e]) begin
          exec_o[e]  <= 1'b1;
          data_q[e]  <= cmpl_data_i;
          cause_q[e] <= cmpl_cause_i;
        end
      end
    end
  end

  assign head_dest_o  = dest_q[head_ptr_i];
  assign head_data_o  = data_q[head_ptr_i];
  assign head_cause_o = cause_q[head_ptr_i];
  assign head_store_o = store_q[head_ptr_i];

  AST_STALE_CMPL_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_valid_i && !use_o[cmpl_idx_i]) |=> !exec_o[$past(cmpl_idx_i)]); // R9

endmodule

// File: rtl/rob_top.sv
module rob_top
  import rob_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int DATA_W  = 32,
  parameter int DEST_W  = 5,
  parameter int CAUSE_W = 4,
  parameter int NUM_BR  = 2,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    alloc_valid_i,
  input  logic [DEST_W-1:0]       alloc_dest_i,
  input  logic                    alloc_store_i,
  output logic                    alloc_ready_o,
  output logic [IDX_W-1:0]        alloc_idx_o,
  input  logic                    cmpl_valid_i,
  input  logic [IDX_W-1:0]        cmpl_idx_i,
  input  logic [DATA_W-1:0]       cmpl_data_i,
  input  logic [CAUSE_W-1:0]      cmpl_cause_i,
  input  logic [NUM_BR-1:0]       mp_valid_i,
  input  logic [NUM_BR*IDX_W-1:0] mp_idx_i,
  output logic                    cmt_valid_o,
  output logic [DEST_W-1:0]       cmt_dest_o,
  output logic [DATA_W-1:0]       cmt_data_o,
  output logic                    cmt_store_o,
  output logic                    cmt_excp_o,
  output logic [CAUSE_W-1:0]      cmt_cause_o,
  output logic                    full_o,
  output logic                    empty_o
);

  logic [IDX_W-1:0]   alloc_ptr, head_ptr, rb_idx;
  logic               rb_valid;
  logic [DEPTH-1:0]   use_q, exec_q;
  logic [DEST_W-1:0]  head_dest;
  logic [DATA_W-1:0]  head_data;
  logic [CAUSE_W-1:0] head_cause;
  logic               head_store;
  logic               head_done, exc_hit, commit_fire, alloc_fire;
  flush_e             flush;

  rob_oldest_sel #(.DEPTH(DEPTH), .NUM_BR(NUM_BR)) u_sel (
    .head_i     (head_ptr),
    .mp_valid_i (mp_valid_i),
    .mp_idx_i   (mp_idx_i),
    .rb_valid_o (rb_valid),
    .rb_idx_o   (rb_idx)
  );

  rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .alloc_fire_i  (alloc_fire),
    .commit_fire_i (commit_fire),
    .flush_i       (flush),
    .rb_idx_i      (rb_idx),
    .alloc_ptr_o   (alloc_ptr),
    .head_ptr_o    (head_ptr)
  );

  rob_entry_array #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W), .CAUSE_W(CAUSE_W)
  ) u_arr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .alloc_fire_i  (alloc_fire),
    .alloc_ptr_i   (alloc_ptr),
    .alloc_dest_i  (alloc_dest_i),
    .alloc_store_i (alloc_store_i),
    .cmpl_valid_i  (cmpl_valid_i),
    .cmpl_idx_i    (cmpl_idx_i),
    .cmpl_data_i   (cmpl_data_i),
    .cmpl_cause_i  (cmpl_cause_i),
    .commit_fire_i (commit_fire),
    .head_ptr_i    (head_ptr),
    .flush_i       (flush),
    .rb_idx_i      (rb_idx),
    .use_o         (use_q),
    .exec_o        (exec_q),
    .head_dest_o   (head_dest),
    .head_data_o   (head_data),
    .head_cause_o  (head_cause),
    .head_store_o  (head_store)
  );

  assign head_done   = use_q[head_ptr] && exec_q[head_ptr];
  assign exc_hit     = head_done && (head_cause != '0);
  assign commit_fire = head_done && (head_cause == '0);

  // exception outranks rollback; either blocks allocation
  assign flush = exc_hit ? FL_EXCP : (rb_valid ? FL_ROLL : FL_NONE);

  assign full_o        = use_q[alloc_ptr];
  assign empty_o       = !use_q[head_ptr];
  assign alloc_ready_o = !full_o;
  assign alloc_fire    = alloc_valid_i && !full_o && (flush == FL_NONE);
  assign alloc_idx_o   = alloc_ptr;

  assign cmt_valid_o = commit_fire;
  assign cmt_dest_o  = head_dest;
  assign cmt_data_o  = head_data;
  assign cmt_store_o = commit_fire && head_store;
  assign cmt_excp_o  = exc_hit;
  assign cmt_cause_o = head_cause;

  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o)); // R3

  AST_EXC_DRAINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmt_excp_o |=> (empty_o && alloc_idx_o == $past(head_ptr))); // R6

  AST_RETIRE_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmt_valid_o |=> !use_q[$past(head_ptr)]); // R4

  AST_ROLLBACK_NO_GROWTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush == FL_ROLL) |=> ($countones(use_q) <= $past($countones(use_q)))); // R7

endmodule

// File: tb/rob_top_bench.sv
`timescale 1ns/1ps
module rob_top_bench;
  localparam int D  = 8;
  localparam int IW = 3;

  typedef struct packed {
    logic [IW-1:0] idx;
    logic [4:0]    dest;
    logic [31:0]   data;
    logic          st;
    logic [3:0]    cause;
  } item_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic alloc_valid_i = 1'b0;
  logic [4:0] alloc_dest_i = '0;
  logic alloc_store_i = 1'b0;
  logic alloc_ready_o;
  logic [IW-1:0] alloc_idx_o;
  logic cmpl_valid_i = 1'b0;
  logic [IW-1:0] cmpl_idx_i = '0;
  logic [31:0] cmpl_data_i = '0;
  logic [3:0] cmpl_cause_i = '0;
  logic [1:0] mp_valid_i = '0;
  logic [2*IW-1:0] mp_idx_i = '0;
  logic cmt_valid_o, cmt_store_o, cmt_excp_o, full_o, empty_o;
  logic [4:0] cmt_dest_o;
  logic [31:0] cmt_data_o;
  logic [3:0] cmt_cause_o;

  rob_top #(.DEPTH(D), .DATA_W(32), .DEST_W(5), .CAUSE_W(4), .NUM_BR(2)) u_rob_top (
    .clk_i, .rst_ni, .alloc_valid_i, .alloc_dest_i, .alloc_store_i, .alloc_ready_o,
    .alloc_idx_o, .cmpl_valid_i, .cmpl_idx_i, .cmpl_data_i, .cmpl_cause_i,
    .mp_valid_i, .mp_idx_i, .cmt_valid_o, .cmt_dest_o, .cmt_data_o, .cmt_store_o,
    .cmt_excp_o, .cmt_cause_o, .full_o, .empty_o
  );

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, nx = 0, ser = 0;
  item_t exp_q[$];
  item_t it;
  logic [31:0] pl_data [D];
  logic [3:0]  pl_cause [D];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // scoreboard monitor: one expected item per retirement, in program order
  always @(negedge clk_i) begin
    if (rst_ni && (cmt_valid_o || cmt_excp_o)) begin
      if (exp_q.size() == 0) begin
        chk(0, "R7 unexpected retirement", 64'(cmt_data_o), 0);
      end else begin
        it = exp_q.pop_front();
        if (it.cause != 0) begin
          chk(cmt_excp_o && !cmt_valid_o && cmt_cause_o == it.cause, "R6 exception cause",
              {cmt_excp_o, cmt_valid_o, cmt_cause_o}, {1'b1, 1'b0, it.cause});
          exp_q.delete();
        end else begin
          chk(cmt_valid_o && cmt_dest_o == it.dest && cmt_data_o == it.data, "R4 in-order retire",
              {cmt_dest_o, cmt_data_o}, {it.dest, it.data});
          chk(cmt_store_o == it.st, "R5 store permission", 64'(cmt_store_o), 64'(it.st));
        end
      end
    end
  end

  task automatic do_alloc(input logic [4:0] d, input bit st, input logic [3:0] cs);
    item_t ni;
    chk(alloc_ready_o && alloc_idx_o == IW'(nx), "R2 alloc index", 64'(alloc_idx_o), 64'(nx));
    ni.idx = alloc_idx_o; ni.dest = d; ni.st = st; ni.cause = cs;
    ni.data = 32'hD000_0000 + 32'(ser);
    ser++;
    pl_data[ni.idx] = ni.data;
    pl_cause[ni.idx] = cs;
    exp_q.push_back(ni);
    alloc_valid_i = 1'b1; alloc_dest_i = d; alloc_store_i = st;
    tick();
    alloc_valid_i = 1'b0; alloc_store_i = 1'b0;
    nx = (nx + 1) % D;
  endtask

  task automatic do_cmpl(input logic [IW-1:0] id);
    cmpl_valid_i = 1'b1; cmpl_idx_i = id;
    cmpl_data_i = pl_data[id]; cmpl_cause_i = pl_cause[id];
    tick();
    cmpl_valid_i = 1'b0;
  endtask

  task automatic do_mp(input bit v0, input logic [IW-1:0] b0, input bit v1,
                       input logic [IW-1:0] b1, input bit with_alloc);
    int p0 = D, p1 = D;
    logic [IW-1:0] win;
    foreach (exp_q[k]) begin
      if (exp_q[k].idx == b0) p0 = k;
      if (exp_q[k].idx == b1) p1 = k;
    end
    win = (!v1 || (v0 && p0 <= p1)) ? b0 : b1;
    while (exp_q.size() > 0 && exp_q[$].idx != win) void'(exp_q.pop_back());
    mp_valid_i = {v1, v0}; mp_idx_i = {b1, b0}; alloc_valid_i = with_alloc;
    tick();
    mp_valid_i = '0; alloc_valid_i = 1'b0;
    nx = (int'(win) + 1) % D;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    chk(0, "watchdog", 0, 0);
    report();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk(empty_o == 1'b1, "R1 empty", 64'(empty_o), 1);
    chk(full_o == 1'b0 && alloc_ready_o == 1'b1, "R1 full/ready", {full_o, alloc_ready_o}, 2'b01);
    chk(alloc_idx_o == 0, "R1 alloc index", 64'(alloc_idx_o), 0);
    chk(cmt_valid_o == 1'b0, "R1 no retire", 64'(cmt_valid_o), 0);

    // out-of-order completion, in-order retirement
    do_alloc(5'd1, 0, 0); do_alloc(5'd2, 1, 0); do_alloc(5'd3, 0, 0); do_alloc(5'd4, 0, 0);
    do_cmpl(3'd2);
    chk(cmt_valid_o == 1'b0, "R4 head not done", 64'(cmt_valid_o), 0);
    do_cmpl(3'd0); do_cmpl(3'd3); do_cmpl(3'd1);
    repeat (4) tick();
    chk(empty_o == 1'b1, "R3 empty after drain", 64'(empty_o), 1);

    // fill across the wrap point
    for (int k = 0; k < D; k++) do_alloc(5'(8 + k), k[0], 0);
    chk(full_o == 1'b1 && alloc_ready_o == 1'b0, "R3 full", {full_o, alloc_ready_o}, 2'b10);
    chk(empty_o == 1'b0, "R3 not empty", 64'(empty_o), 0);
    alloc_valid_i = 1'b1; tick(); alloc_valid_i = 1'b0;
    chk(alloc_idx_o == IW'(nx) && full_o, "R3 refused when full", 64'(alloc_idx_o), 64'(nx));
    for (int k = 3; k >= 0; k--) do_cmpl(IW'(k));
    for (int k = 7; k >= 4; k--) do_cmpl(IW'(k));
    repeat (9) tick();
    chk(empty_o == 1'b1, "R3 empty after full drain", 64'(empty_o), 1);

    // exception at head, allocation during flush discarded
    do_alloc(5'd20, 0, 0); do_alloc(5'd21, 1, 4'h9); do_alloc(5'd22, 0, 0);
    do_cmpl(3'd6); do_cmpl(3'd5); do_cmpl(3'd4);
    tick();
    alloc_valid_i = 1'b1; tick(); alloc_valid_i = 1'b0;
    chk(empty_o == 1'b1, "R6 flushed", 64'(empty_o), 1);
    chk(alloc_idx_o == 3'd5, "R6 alloc at faulting slot", 64'(alloc_idx_o), 5);
    chk(cmt_valid_o == 1'b0, "R10 no retire after flush", 64'(cmt_valid_o), 0);
    nx = 5;

    // rollback with younger completed slot, allocation in same cycle
    do_alloc(5'd23, 0, 0); do_alloc(5'd24, 0, 0); do_alloc(5'd25, 0, 0);
    do_alloc(5'd26, 0, 0); do_alloc(5'd27, 0, 0);
    do_cmpl(3'd0);
    do_mp(1, 3'd6, 0, 3'd0, 1);
    chk(alloc_idx_o == 3'd7, "R7 rollback index", 64'(alloc_idx_o), 7);
    chk(alloc_idx_o == 3'd7, "R10 alloc during rollback dropped", 64'(alloc_idx_o), 7);
    do_cmpl(3'd7);
    chk(cmt_valid_o == 1'b0, "R9 stale completion", 64'(cmt_valid_o), 0);
    do_cmpl(3'd5); do_cmpl(3'd6);
    repeat (3) tick();
    chk(empty_o == 1'b1, "R7 younger discarded", 64'(empty_o), 1);
    do_alloc(5'd28, 0, 0);
    chk(cmt_valid_o == 1'b0 && empty_o == 1'b0, "R9 new slot waits", {cmt_valid_o, empty_o}, 2'b00);
    tick();
    chk(cmt_valid_o == 1'b0, "R9 new slot still waits", 64'(cmt_valid_o), 0);
    do_cmpl(3'd7);
    repeat (2) tick();
    chk(empty_o == 1'b1, "R9 retired after own completion", 64'(empty_o), 1);

    // two mispredicts in one cycle: older branch wins
    for (int k = 0; k < 6; k++) do_alloc(5'(k), 0, 0);
    do_mp(1, 3'd4, 1, 3'd2, 0);
    chk(alloc_idx_o == 3'd3, "R8 older branch wins (port 1)", 64'(alloc_idx_o), 3);
    do_cmpl(3'd0); do_cmpl(3'd1); do_cmpl(3'd2);
    repeat (3) tick();
    chk(empty_o == 1'b1, "R11 older slots retired", 64'(empty_o), 1);
    do_alloc(5'd10, 1, 0); do_alloc(5'd11, 0, 0); do_alloc(5'd12, 0, 0);
    do_mp(1, 3'd3, 1, 3'd4, 0);
    chk(alloc_idx_o == 3'd4, "R8 older branch wins (port 0)", 64'(alloc_idx_o), 4);
    do_cmpl(3'd3);
    repeat (2) tick();
    chk(empty_o == 1'b1, "R11 branch slot retired", 64'(empty_o), 1);
    chk(exp_q.size() == 0, "R7 all expected retired", 64'(exp_q.size()), 0);
    report();
  end
endmodule